// File: doc/BRIEF.md
# M/N:D Fractional Clock Divider

This block divides an input clock by the rational ratio N/M, so that on average M output periods occur for every N input cycles. A phase accumulator advances by M on every input edge. When the sum reaches N, N is subtracted and the block emits a period tick. The divided clock is high while the phase lies in the lower part of its range, and a D value sets where that part ends. This gives software a duty-cycle control that is independent of the ratio.

The three ratio fields arrive in their stored encodings:
- M is stored as is.
- The N field holds the complement of N-M.
- The D field holds the complement of D.

The block decodes these fields itself and loads the result only on an update strobe, so a sequence of register writes never shows up half-applied. A mode value of zero selects pass-through, and so does any ratio that cannot divide. In pass-through the input clock is forwarded and the tick is asserted on every cycle.

Top module: `mnd_frac_div`

## Requirements
- R1: With counter width W (default 8), the decoded ratio is M = m_raw_i, N = (~n_raw_i + m_raw_i) mod 2^W and D = ~d_raw_i mod 2^W, taken when upd_i is sampled high.
- R2: In divide mode, tick_o is high for exactly M of every N cycles after an update. For M=1, N=4 this gives 100 ticks in 400 cycles, and for M=3, N=8 it gives 150.
- R3: In divide mode the internal phase always stays below N.
- R4: In divide mode, clk_o after an edge is high exactly when twice the new phase is below D. M=1, N=4, D=4 gives 200 high cycles in 400, and M=3, N=8, D=4 gives 100.
- R5: Mode encoding is 0 for pass-through and 1, 2 or 3 for counting. Mode 0, decoded N = 0, or M >= N selects pass-through. In pass-through, tick_o is 1 on every cycle and clk_o equals clk_i.
- R6: An update clears the phase. In divide mode, tick_o and clk_o are 0 in the cycle after the update edge, even when a wrap was due at that edge.
- R7: Changes on m_raw_i, n_raw_i, d_raw_i and mode_i have no effect while upd_i is low.
- R8: During reset tick_o is 0 and the block is in pass-through, so clk_o equals clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Load strobe for the raw fields |
| mode_i | input | 2 | 0 pass-through, nonzero counting |
| m_raw_i | input | CNT_W | M as stored |
| n_raw_i | input | CNT_W | Complement of N-M |
| d_raw_i | input | CNT_W | Complement of D |
| clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One cycle per output period |

## Verification
An update strobe and an accumulator wrap can land on the same input edge. In that case the update must win: the phase restarts at zero and no tick appears. The bench loads M=1, N=4 and reasserts the update exactly on the fourth edge, where a wrap would otherwise fire. It then expects tick_o low after that edge, three quiet cycles, and the next tick four edges after the second update.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SGL  = 2'd1,
    MODE_DUAL = 2'd2,
    MODE_ALT  = 2'd3
  } mnd_mode_e;

  function automatic logic mode_is_off(input logic [1:0] mode);
    return mode == MODE_OFF;
  endfunction
endpackage

// File: rtl/mnd_cfg.sv
module mnd_cfg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] m_raw_i,
  input  logic [CNT_W-1:0] n_raw_i,
  input  logic [CNT_W-1:0] d_raw_i,
  output logic [CNT_W-1:0] m_o,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] d_o,
  output logic             byp_o,
  output logic             byp_d_o
);
  import mnd_pkg::*;

  logic [CNT_W-1:0] n_dec, d_dec;

  always_comb begin
    n_dec   = (~n_raw_i) + m_raw_i;  // wraps at CNT_W
    d_dec   = ~d_raw_i;
    byp_d_o = mode_is_off(mode_i) || (n_dec == '0) || (m_raw_i >= n_dec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o   <= '0;
      n_o   <= '0;
      d_o   <= '0;
      byp_o <= 1'b1;
    end else if (upd_i) begin
      m_o   <= m_raw_i;
      n_o   <= n_dec;
      d_o   <= d_dec;
      byp_o <= byp_d_o;
    end
  end
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             byp_d_i,
  input  logic             byp_q_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] n_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] acc_nxt_o,
  output logic             tick_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum, diff;
  logic             wrap;

  always_comb begin
    sum       = {1'b0, acc_o} + {1'b0, m_i};
    diff      = sum - {1'b0, n_i};
    wrap      = sum >= {1'b0, n_i};
    acc_nxt_o = wrap ? diff[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      tick_o <= 1'b0;
    end else if (upd_i) begin
      acc_o  <= '0;
      tick_o <= byp_d_i;
    end else if (byp_q_i) begin
      acc_o  <= '0;
      tick_o <= 1'b1;
    end else begin
      acc_o  <= acc_nxt_o;
      tick_o <= wrap;
    end
  end
endmodule

// File: rtl/mnd_duty.sv
module mnd_duty #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             byp_q_i,
  input  logic [CNT_W-1:0] acc_nxt_i,
  input  logic [CNT_W-1:0] d_i,
  output logic             div_o
);
  logic hi;

  // phase*2 < D: D equal to N gives half duty
  assign hi = {acc_nxt_i, 1'b0} < {1'b0, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_o <= 1'b0;
    else if (upd_i || byp_q_i)  div_o <= 1'b0;
    else                        div_o <= hi;
  end
endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] m_raw_i,
  input  logic [CNT_W-1:0] n_raw_i,
  input  logic [CNT_W-1:0] d_raw_i,
  output logic             clk_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] m_q, n_q, d_q, acc_q, acc_nxt;
  logic             byp_q, byp_d, div_q;

  mnd_cfg #(.CNT_W(CNT_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_i),
    .mode_i  (mode_i),
    .m_raw_i (m_raw_i),
    .n_raw_i (n_raw_i),
    .d_raw_i (d_raw_i),
    .m_o     (m_q),
    .n_o     (n_q),
    .d_o     (d_q),
    .byp_o   (byp_q),
    .byp_d_o (byp_d)
  );

  mnd_accum #(.CNT_W(CNT_W)) i_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .byp_d_i   (byp_d),
    .byp_q_i   (byp_q),
    .m_i       (m_q),
    .n_i       (n_q),
    .acc_o     (acc_q),
    .acc_nxt_o (acc_nxt),
    .tick_o    (tick_o)
  );

  mnd_duty #(.CNT_W(CNT_W)) i_duty (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .byp_q_i   (byp_q),
    .acc_nxt_i (acc_nxt),
    .d_i       (d_q),
    .div_o     (div_q)
  );

  assign clk_o = byp_q ? clk_i : div_q;
endmodule

// File: rtl/mnd_frac_div_chk.sv
module mnd_frac_div_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_i,
  input logic             tick_o,
  input logic             byp_q,
  input logic [CNT_W-1:0] acc_q,
  input logic [CNT_W-1:0] m_q,
  input logic [CNT_W-1:0] n_q,
  input logic [CNT_W-1:0] d_q
);
  assert_upd_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (byp_q || !tick_o));

  assert_byp_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && byp_q) |=> tick_o);

  assert_phase_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_q |-> (acc_q < n_q));

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable({m_q, n_q, d_q, byp_q}));

  assert_tick_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && tick_o) |-> (acc_q < m_q));
endmodule

bind mnd_frac_div mnd_frac_div_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .upd_i  (upd_i),
  .tick_o (tick_o),
  .byp_q  (byp_q),
  .acc_q  (acc_q),
  .m_q    (m_q),
  .n_q    (n_q),
  .d_q    (d_q)
);

// File: tb/test_mnd_frac_div.sv
module test_mnd_frac_div;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         upd_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [W-1:0] m_raw_i = '0, n_raw_i = '0, d_raw_i = '0;
  logic         clk_o, tick_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  mnd_frac_div #(.CNT_W(W)) i_mnd_frac_div (
    .clk_i, .rst_ni, .upd_i, .mode_i, .m_raw_i, .n_raw_i, .d_raw_i, .clk_o, .tick_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive raw fields with upd high for one edge; returns at the negedge after it
  task automatic load(input logic [1:0] md, input int m, input int n, input int d);
    @(negedge clk_i);
    mode_i  = md;
    m_raw_i = W'(m);
    n_raw_i = ~W'(n - m);
    d_raw_i = ~W'(d);
    upd_i   = 1'b1;
    @(negedge clk_i);
    upd_i   = 1'b0;
  endtask

  task automatic count(input int cyc, output int ticks, output int highs);
    ticks = 0; highs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      ticks += int'(tick_o);
      highs += int'(clk_o);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R8 tick in reset", int'(tick_o), 0);
    chk("R8 clk_o low phase in reset", int'(clk_o), 0);
    @(posedge clk_i); #1;
    chk("R8 clk_o high phase in reset", int'(clk_o), 1);
  endtask

  task automatic t_m1n4;
    int t, h;
    load(2'd2, 1, 4, 4);
    chk("R6 tick after update", int'(tick_o), 0);
    chk("R6 clk_o after update", int'(clk_o), 0);
    count(400, t, h);
    chk("R1 R2 ticks M1 N4", t, 100);
    chk("R4 highs M1 N4 D4", h, 200);
  endtask

  task automatic t_m3n8;
    int t, h;
    load(2'd1, 3, 8, 4);
    count(400, t, h);
    chk("R1 R2 ticks M3 N8", t, 150);
    chk("R4 highs M3 N8 D4", h, 100);
  endtask

  task automatic t_ignore;
    int t, h;
    load(2'd2, 1, 4, 4);
    @(negedge clk_i);
    mode_i = 2'd0; m_raw_i = 8'd3; n_raw_i = 8'h00; d_raw_i = 8'h00;
    count(399, t, h);
    chk("R7 ticks with unloaded change", t, 100);
    chk("R7 highs with unloaded change", h, 199);
  endtask

  task automatic t_collide;
    load(2'd2, 1, 4, 4);
    repeat (3) @(negedge clk_i);
    upd_i = 1'b1;  // coincides with the edge where a wrap is due
    @(negedge clk_i);
    upd_i = 1'b0;
    chk("R6 update beats wrap", int'(tick_o), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R6 quiet after collision", int'(tick_o), 0);
    end
    @(negedge clk_i);
    chk("R6 tick resumes", int'(tick_o), 1);
  endtask

  task automatic t_bypass(input string tag, input logic [1:0] md, input int m, input logic [W-1:0] nraw);
    @(negedge clk_i);
    mode_i = md; m_raw_i = W'(m); n_raw_i = nraw; d_raw_i = 8'hF0; upd_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk({tag, " tick every cycle"}, int'(tick_o), 1);
      chk({tag, " clk_o low phase"}, int'(clk_o), 0);
      @(posedge clk_i); #1;
      chk({tag, " clk_o high phase"}, int'(clk_o), 1);
      @(negedge clk_i);
    end
  endtask

  initial begin
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_m1n4();
    t_m3n8();
    t_ignore();
    t_collide();
    t_bypass("R5 mode0", 2'd0, 1, ~8'd3);
    t_bypass("R5 M>N", 2'd2, 200, 8'd155);
    t_bypass("R5 N=0", 2'd2, 5, 8'd4);
    t_bypass("R5 M=N", 2'd3, 6, 8'hFF);
    t_m1n4();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule